// File: doc/BRIEF.md
# Read-Enable to Valid/Ready Stream Bridge

This block sits between a symbol producer that is paced by a read-enable request and a consumer that uses valid/ready flow control. The bridge drives a request line toward the producer. When the producer sees that request at a clock edge, it answers at the next edge with a beat: a valid bit, one symbol of `SYM_W` bits, codeword start and end flags, and an erasure mark for that symbol. When the request is low, the producer's outputs hold their old values. A beat therefore counts only when the valid bit is paired with a request issued one cycle earlier, so that a held valid is never counted twice.

Accepted beats go into a small skid buffer of `DEPTH` entries. The buffer covers the request that is already in flight when the consumer stalls. The buffer head appears on the output with the same fields. Beats move one to one, in order. A sticky error output reports broken codeword framing on the input side. It stays set until reset.

Top module: `rden_stream_bridge`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after `rst_n` rises, `rd_en` is low.
- R2: An input beat is accepted only in a cycle where `in_valid` is high and `rd_en` was high in the cycle before. A valid held while no request was pending is not accepted again. Every produced beat is delivered exactly once.
- R3: Beats leave in arrival order, with the symbol, start flag, end flag and erasure mark unchanged.
- R4: After the first cycle out of reset, `rd_en` is high exactly when the buffer has at least two free entries, or when it has one free entry and an output transfer (`out_valid` and `out_ready`) happens in the same cycle.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high at the next edge and `out_sym`, `out_sop`, `out_eop` and `out_erase` do not change.
- R6: `out_valid` is high exactly when the buffer holds at least one beat. Reset empties the buffer.
- R7: An accepted beat with the start flag set, arriving while a codeword is open, sets `frm_err`. A codeword opens on an accepted beat with the start flag and closes on an accepted beat with the end flag.
- R8: An accepted beat without the start flag, arriving while no codeword is open, sets `frm_err`. This covers an end flag that would close a codeword that was never opened.
- R9: `frm_err` is low after reset, stays high once set until the next reset, and stays low through well-framed traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | output | 1 | Read request toward the producer |
| in_valid | input | 1 | Producer beat valid, updated on edges after a request |
| in_sym | input | SYM_W | Producer symbol |
| in_sop | input | 1 | First beat of a codeword |
| in_eop | input | 1 | Last beat of a codeword |
| in_erase | input | 1 | Erasure mark for the symbol |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Consumer takes the output beat |
| out_sym | output | SYM_W | Output symbol |
| out_sop | output | 1 | Output start flag |
| out_eop | output | 1 | Output end flag |
| out_erase | output | 1 | Output erasure mark |
| frm_err | output | 1 | Sticky framing error |

## Verification
The hardest case to reach is the edge of the buffer. A request is already in flight, only one entry is free, and the consumer either takes a beat in that same cycle or does not. Whether the request may stay high depends on that one cycle. The stimulus gets there with bursts from an always-ready producer against a consumer whose ready is low most of the time. A cycle-accurate model in the bench then checks the request line and the buffer contents on every clock. A slow-producer phase leaves valid held high across cycles with no request, and this tests that held beats are not accepted again.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

  // number of flag bits carried beside the symbol: erasure, start, end
  localparam int FLAG_W = 3;

  // codeword framing state on the accepted input stream
  typedef enum logic {
    CW_OUTSIDE = 1'b0,
    CW_INSIDE  = 1'b1
  } cw_state_e;

endpackage

// File: rtl/rdb_capture.sv
module rdb_capture #(
  parameter int BEAT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              in_valid,
  input  logic [BEAT_W-1:0] in_beat,
  output logic              push,
  output logic [BEAT_W-1:0] push_beat
);

  logic req_q;
  logic req_d;

  // next state: remember whether a request was issued this cycle
  always_comb begin
    req_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  // a beat is new only if the producer was asked for it one cycle ago
  always_comb begin
    push      = in_valid & req_q;
    push_beat = in_beat;
  end

endmodule

// File: rtl/rdb_skid_buf.sv
module rdb_skid_buf #(
  parameter int BEAT_W = 11,
  parameter int DEPTH  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [BEAT_W-1:0]            push_beat,
  input  logic                         pop,
  output logic                         out_valid,
  output logic [BEAT_W-1:0]            out_beat,
  output logic [$clog2(DEPTH+1)-1:0]   free_cnt
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] wr_q, wr_d;
  logic [PTR_W-1:0] rd_q, rd_d;
  logic [BEAT_W-1:0] ent_q [DEPTH];
  logic [DEPTH-1:0]  ent_we;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) begin
      return '0;
    end
    return p + 1'b1;
  endfunction

  // next-state for occupancy and pointers
  always_comb begin
    cnt_d = cnt_q;
    wr_d  = wr_q;
    rd_d  = rd_q;
    if (push) begin
      wr_d = ptr_inc(wr_q);
    end
    if (pop) begin
      rd_d = ptr_inc(rd_q);
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      wr_q  <= wr_d;
      rd_q  <= rd_d;
    end
  end

  // storage entries, each with its own write enable
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    assign ent_we[gi] = push && (wr_q == PTR_W'(gi));
    always_ff @(posedge clk) begin
      if (ent_we[gi]) begin
        ent_q[gi] <= push_beat;
      end
    end
  end

  always_comb begin
    out_valid = (cnt_q != '0);
    out_beat  = ent_q[rd_q];
    free_cnt  = CNT_W'(DEPTH) - cnt_q;
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt_q < CNT_W'(DEPTH)));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

endmodule

// File: rtl/rdb_frame_chk.sv
module rdb_frame_chk (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic beat_sop,
  input  logic beat_eop,
  output logic frm_err
);

  import rdb_pkg::*;

  cw_state_e cw_q, cw_d;
  logic      err_q, err_d;
  logic      open_now;

  // next-state: track the open codeword, latch any violation
  always_comb begin
    cw_d     = cw_q;
    err_d    = err_q;
    open_now = (cw_q == CW_INSIDE);
    if (push) begin
      if (beat_sop && open_now) begin
        err_d = 1'b1;
      end
      if (!beat_sop && !open_now) begin
        err_d = 1'b1;
      end
      if (beat_eop) begin
        cw_d = CW_OUTSIDE;
      end else if (beat_sop || open_now) begin
        cw_d = CW_INSIDE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q  <= CW_OUTSIDE;
      err_q <= 1'b0;
    end else begin
      cw_q  <= cw_d;
      err_q <= err_d;
    end
  end

  assign frm_err = err_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |=> frm_err);

  // R7 R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_err) |-> $past(push));

endmodule

// File: rtl/rdb_req_ctl.sv
module rdb_req_ctl #(
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH+1)-1:0] free_cnt,
  input  logic                       pop,
  output logic                       rd_en
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic run_q, run_d;

  // the request path stays off for the first cycle after reset
  always_comb begin
    run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  // one request may be in flight: keep room for it after this cycle
  always_comb begin
    rd_en = run_q &&
            ((free_cnt >= CNT_W'(2)) || ((free_cnt == CNT_W'(1)) && pop));
  end

  // R4
  no_req_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == '0) |-> !rd_en);

endmodule

// File: rtl/rden_stream_bridge.sv
module rden_stream_bridge #(
  parameter int SYM_W     = 8,
  parameter int DEPTH     = 2,
  parameter int HAS_ERASE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             rd_en,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_sym,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic             in_erase,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_sym,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_erase,
  output logic             frm_err
);

  localparam int BEAT_W = SYM_W + rdb_pkg::FLAG_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int EOP_B  = SYM_W;
  localparam int SOP_B  = SYM_W + 1;
  localparam int ERA_B  = SYM_W + 2;

  logic              erase_in;
  logic [BEAT_W-1:0] in_beat;
  logic              push;
  logic [BEAT_W-1:0] push_beat;
  logic              pop;
  logic [BEAT_W-1:0] head_beat;
  logic [CNT_W-1:0]  free_cnt;

  if (HAS_ERASE != 0) begin : g_erase
    assign erase_in = in_erase;
  end else begin : g_no_erase
    assign erase_in = 1'b0;
  end

  assign in_beat = {erase_in, in_sop, in_eop, in_sym};

  rdb_capture #(.BEAT_W(BEAT_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .in_valid  (in_valid),
    .in_beat   (in_beat),
    .push      (push),
    .push_beat (push_beat)
  );

  rdb_skid_buf #(.BEAT_W(BEAT_W), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_beat (push_beat),
    .pop       (pop),
    .out_valid (out_valid),
    .out_beat  (head_beat),
    .free_cnt  (free_cnt)
  );

  assign pop = out_valid & out_ready;

  rdb_frame_chk u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .beat_sop (push_beat[SOP_B]),
    .beat_eop (push_beat[EOP_B]),
    .frm_err  (frm_err)
  );

  rdb_req_ctl #(.DEPTH(DEPTH)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .free_cnt (free_cnt),
    .pop      (pop),
    .rd_en    (rd_en)
  );

  assign out_sym   = head_beat[SYM_W-1:0];
  assign out_eop   = head_beat[EOP_B];
  assign out_sop   = head_beat[SOP_B];
  assign out_erase = head_beat[ERA_B];

  // R5
  stable_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) &&
      $stable(out_sop) && $stable(out_eop) && $stable(out_erase)));

endmodule

// File: tb/rden_stream_bridge_test.sv
module rden_stream_bridge_test;

  localparam int CLK_PERIOD = 10;
  localparam int SYM_W      = 8;
  localparam int DEPTH      = 2;
  localparam int BW         = SYM_W + 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rd_en;
  logic             in_valid = 1'b0;
  logic [SYM_W-1:0] in_sym = '0;
  logic             in_sop = 1'b0;
  logic             in_eop = 1'b0;
  logic             in_erase = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [SYM_W-1:0] out_sym;
  logic             out_sop;
  logic             out_eop;
  logic             out_erase;
  logic             frm_err;

  rden_stream_bridge #(.SYM_W(SYM_W), .DEPTH(DEPTH), .HAS_ERASE(1)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
    .in_valid(in_valid), .in_sym(in_sym), .in_sop(in_sop), .in_eop(in_eop),
    .in_erase(in_erase), .out_valid(out_valid), .out_ready(out_ready),
    .out_sym(out_sym), .out_sop(out_sop), .out_eop(out_eop),
    .out_erase(out_erase), .frm_err(frm_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // beat layout in the bench: {erase, sop, eop, sym}
  logic [BW-1:0] srcq[$];
  logic [BW-1:0] mq[$];
  int  produced = 0;
  int  delivered = 0;
  bit  m_run = 0;
  bit  m_reqd = 0;
  bit  m_open = 0;
  bit  m_err = 0;
  string m_cause = "R9";
  int  vpct = 100;
  int  rpct = 100;

  // per-cycle samples
  bit            s_rst, s_en, s_ival, s_rdy, s_oval, exp_en;
  logic [BW-1:0] s_ibeat, s_obeat, p_obeat;
  bit            p_stall = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    s_rst   = rst_n;
    s_en    = rd_en;
    s_ival  = in_valid;
    s_ibeat = {in_erase, in_sop, in_eop, in_sym};
    s_rdy   = out_ready;
    s_oval  = out_valid;
    s_obeat = {out_erase, out_sop, out_eop, out_sym};
    if (!s_rst) begin
      chk(!s_en, "R1", "rd_en in reset", s_en, 0);
      chk(!s_oval, "R6", "out_valid in reset", s_oval, 0);
      chk(!frm_err, "R9", "frm_err in reset", frm_err, 0);
      p_stall = 0;
    end else begin
      exp_en = m_run && ((DEPTH - mq.size() >= 2) ||
               ((DEPTH - mq.size() == 1) && mq.size() != 0 && s_rdy));
      chk(s_en == exp_en, m_run ? "R4" : "R1", "rd_en", s_en, exp_en);
      chk(s_oval == (mq.size() != 0), "R6", "out_valid", s_oval, mq.size() != 0);
      if (s_oval && mq.size() != 0)
        chk(s_obeat == mq[0], "R3", "head beat", s_obeat, mq[0]);
      if (p_stall)
        chk(s_oval && s_obeat == p_obeat, "R5", "stalled output", s_obeat, p_obeat);
      chk(frm_err == m_err, m_cause, "frm_err", frm_err, m_err);
      p_stall = s_oval && !s_rdy;
      p_obeat = s_obeat;
    end
    @(posedge clk);
    if (s_rst) begin
      if (s_oval && s_rdy && mq.size() != 0) begin
        void'(mq.pop_front());
        delivered++;
      end
      if (m_reqd && s_ival) begin
        mq.push_back(s_ibeat);
        if (s_ibeat[SYM_W+1] && m_open) begin m_err = 1; m_cause = "R7"; end
        if (!s_ibeat[SYM_W+1] && !m_open) begin m_err = 1; m_cause = "R8"; end
        m_open = (s_ibeat[SYM_W+1] || m_open) && !s_ibeat[SYM_W];
      end
      m_reqd = exp_en;
      m_run  = 1;
    end
    #1;
    if (rst_n && s_en) begin
      if (srcq.size() != 0 && ($urandom % 100) < vpct) begin
        {in_erase, in_sop, in_eop, in_sym} = srcq.pop_front();
        in_valid = 1'b1;
        produced++;
      end else begin
        in_valid = 1'b0;
        in_sym   = SYM_W'($urandom);
        in_sop   = 1'($urandom);
        in_eop   = 1'($urandom);
      end
    end
    out_ready = (($urandom % 100) < rpct);
  endtask

  task automatic do_reset(input int n);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    mq.delete();
    m_run = 0; m_reqd = 0; m_open = 0; m_err = 0; m_cause = "R9";
    produced = 0; delivered = 0; p_stall = 0;
    for (int i = 0; i < n; i++) step();
    rst_n = 1'b1;
  endtask

  task automatic add_cw(input int len, input bit sop_mid);
    for (int i = 0; i < len; i++)
      srcq.push_back({1'($urandom), (i == 0) || (sop_mid && i == 1),
                      (i == len - 1), SYM_W'($urandom)});
  endtask

  task automatic drain();
    int guard = 0;
    rpct = 100;
    while ((srcq.size() != 0 || mq.size() != 0 || in_valid) && guard < 3000) begin
      step();
      guard++;
    end
    for (int i = 0; i < 4; i++) step();
    // R2: each produced beat delivered once
    chk(produced == delivered, "R2", "beats delivered", delivered, produced);
  endtask

  initial begin
    do_reset(3);
    // R1 R6 R9: state straight after reset
    chk(!rd_en && !out_valid && !frm_err, "R1", "post-reset outputs",
        {rd_en, out_valid, frm_err}, 0);

    vpct = 80; rpct = 80;
    for (int i = 0; i < 30; i++) add_cw(1 + ($urandom % 5), 0);
    while (srcq.size() != 0) step();
    drain();

    // buffer edge: eager producer, mostly stalled consumer
    vpct = 100; rpct = 25;
    for (int i = 0; i < 40; i++) add_cw(1 + ($urandom % 6), 0);
    while (srcq.size() != 0) step();
    drain();

    // slow producer: valid held high across cycles with no request
    vpct = 20; rpct = 60;
    for (int i = 0; i < 15; i++) add_cw(2 + ($urandom % 4), 0);
    while (srcq.size() != 0) step();
    drain();
    chk(!frm_err, "R9", "no error on clean traffic", frm_err, 0);

    // R7: start flag inside an open codeword
    vpct = 90; rpct = 70;
    add_cw(4, 1);
    for (int i = 0; i < 3; i++) add_cw(3, 0);
    while (srcq.size() != 0) step();
    drain();
    chk(frm_err, "R7", "start inside codeword", frm_err, 1);
    for (int i = 0; i < 3; i++) add_cw(2, 0);
    drain();
    chk(frm_err, "R9", "error stays set", frm_err, 1);

    // R8: beat outside a codeword with no start flag
    step();
    do_reset(2);
    chk(!frm_err, "R9", "reset clears error", frm_err, 0);
    srcq.push_back({1'b0, 1'b0, 1'b0, 8'h5a});
    add_cw(3, 0);
    drain();
    chk(frm_err, "R8", "missing start flag", frm_err, 1);

    // R8: end flag closing a codeword that never opened
    step();
    do_reset(2);
    add_cw(2, 0);
    srcq.push_back({1'b1, 1'b0, 1'b1, 8'hc3});
    drain();
    chk(frm_err, "R8", "end of unopened codeword", frm_err, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule